// File: doc/BRIEF.md
# Linked Command-List Walker

This block follows a chain of command packets stored in a word-wide synchronous memory and streams the packet contents to a downstream command consumer. Each packet begins with one header word. The header carries a payload word count and the address of the next packet. The walker reads a header, sends that many payload words out on a valid/ready stream, and then jumps to the next packet. It stops when an address has its end flag set. On `done` it reports an estimated cycle cost for the whole chain.

A malformed list can point back into itself. To catch this, the walker starts tagging headers once a configurable number of packets has been walked. From that point on it sets the end flag in each header it visits. A cycle therefore ends the walk on its second pass. The walker records the address reached at the threshold. After the walk ends it revisits the tagged headers from that address and removes the tags, so the list in memory is left as it was found.

Top module: `chain_walker`

## Requirements
- R1: On `start` the walker takes bits [23:0] of `start_addr` and ignores bits [31:24]. Whenever the current address has bit 23 set, the walk ends. A start address with bit 23 set gives `done` with cost 0, no memory access and no stream output.
- R2: A header word holds the payload count in bits [31:24] and the next-packet address in bits [23:0]. The payload words sit at the word addresses directly after the header and leave the stream in that order.
- R3: Any packet address is reduced to its low 21 bits and read as a byte address. `mem_addr` is byte-address bits [20:2]. Read data appears on `mem_rdata` one cycle after a read request.
- R4: A packet whose count is zero produces no stream words. The walker moves on to the next packet.
- R5: The reported cost adds 10 for every packet visited. For a packet with a non-zero count N it adds a further 5 + N.
- R6: `out_data` stays stable while `out_valid` is high and `out_ready` is low. The walker issues no memory request while a word waits on the stream.
- R7: Let K = LOOP_LIMIT. When the packet with zero-based index K is visited, its next-packet address is recorded. Every packet visited after that has bit 23 of its header set in memory. A cycle in the list therefore ends the walk on its next pass.
- R8: Let V be the number of packets visited. If V > K + 2, a cleanup pass runs after the walk. It starts at the recorded address, follows the low 21 bits of each header, and clears bit 23 in V − K − 2 headers. Memory after the run equals memory before it.
- R9: `busy` is high from the cycle after `start` until the cleanup pass has finished. `done` is a one-cycle pulse raised while `busy` is still high. `cost` holds its value until the next start.
- R10: A `start` pulse while `busy` is high has no effect on the walk in progress or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| start_addr | input | 32 | First packet address; bits [23:0] used |
| busy | output | 1 | Walk or cleanup in progress |
| done | output | 1 | One-cycle completion pulse |
| cost | output | COST_W | Estimated cycle cost of the last walk |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | MEM_ABITS-2 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after request |
| out_valid | output | 1 | Stream word valid |
| out_data | output | 32 | Stream payload word |
| out_ready | input | 1 | Consumer accepts the word |

## Verification
The bench goes after chains that loop back on themselves. A walker that never tags headers would hang there until the watchdog fires. One that clears the wrong number of headers would leave flags set in memory, or strip an end marker, and the before/after memory comparison shows either. Long chains that end normally past the threshold check the V − K − 2 count. Counting one too many would clear the last packet's real end flag. Further cases cover zero-count packets, which a wrong design would turn into stray stream words or a miscounted cost. They also cover address bits 22:21 and 31:24 set, which a wrong design would use to fetch from the wrong words. Random back-pressure shows whether a stalled word gets overwritten or dropped, and a start pulse mid-walk shows whether an active walk gets restarted.

// File: rtl/chain_pkg.sv
// Shared types for the linked command-list walker.
// Assumes a 32-bit header: count in [31:24], next pointer in [23:0].
package chain_pkg;

    localparam int PTR_W   = 24;
    localparam int END_BIT = 23;

    typedef struct packed {
        logic [7:0]       count;
        logic [PTR_W-1:0] next;
    } chain_hdr_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HDR_RD,
        ST_HDR_WAIT,
        ST_TAG_WR,
        ST_PAY_RD,
        ST_PAY_WAIT,
        ST_PAY_OUT,
        ST_CLR_RD,
        ST_CLR_WAIT,
        ST_CLR_WR,
        ST_FIN
    } walk_state_t;

endpackage

// File: rtl/chain_cost.sv
// Cost accumulator for one walk.
// Adds 10 per packet and a further 5 + count when count is non-zero.
// Assumes 'add' pulses once per header fetched; 'clr' has priority.
module chain_cost #(
    parameter int COST_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [7:0]        count,
    output logic [COST_W-1:0] cost
);

    logic [COST_W-1:0] inc;

    // Per-packet increment
    always_comb begin
        inc = COST_W'(10);
        if (count != 8'd0)
            inc = inc + COST_W'(5) + COST_W'(count);
    end

    // Accumulate over the walk, cleared at start
    always_ff @(posedge clk) begin
        if (!rst_n)
            cost <= '0;
        else if (clr)
            cost <= '0;
        else if (add)
            cost <= cost + inc;
    end

endmodule

// File: rtl/chain_guard.sv
// Loop guard: counts packets visited, records the pointer reached at the
// threshold, says when headers must be tagged, and counts the cleanup pass.
// Assumes 'step' pulses once per header, 'clr_load' once after the walk.
module chain_guard #(
    parameter int LOOP_LIMIT = 8192,
    parameter int CNT_W      = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [23:0]      next_ptr,
    input  logic             clr_load,
    input  logic             clr_step,
    output logic             tag,
    output logic             clr_need,
    output logic             clr_last,
    output logic [23:0]      rec_ptr
);

    localparam logic [CNT_W-1:0] LIM    = CNT_W'(LOOP_LIMIT);
    localparam logic [CNT_W-1:0] LIM_P2 = CNT_W'(LOOP_LIMIT + 2);

    logic [CNT_W-1:0] visited;
    logic [CNT_W-1:0] clr_left;
    logic             recorded;

    assign tag      = visited > LIM;
    assign clr_need = recorded && (visited > LIM_P2);
    assign clr_last = clr_left == CNT_W'(1);

    // Packet count and threshold pointer capture
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            visited  <= '0;
            recorded <= 1'b0;
            rec_ptr  <= '0;
        end else if (step) begin
            visited <= visited + CNT_W'(1);
            if (visited == LIM) begin
                recorded <= 1'b1;
                rec_ptr  <= next_ptr;
            end
        end
    end

    // Remaining headers for the cleanup pass
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            clr_left <= '0;
        else if (clr_load)
            clr_left <= visited - LIM_P2;
        else if (clr_step)
            clr_left <= clr_left - CNT_W'(1);
    end

endmodule

// File: rtl/chain_walker.sv
// Linked command-list walker (top).
// Fetches headers, streams payload words with valid/ready, follows next
// pointers until bit 23, tags headers past the loop threshold and clears
// the tags afterwards. Assumes a synchronous memory with one-cycle reads.
module chain_walker #(
    parameter int LOOP_LIMIT = 8192,
    parameter int CNT_W      = 24,
    parameter int COST_W     = 32,
    parameter int MEM_ABITS  = 21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [31:0]          start_addr,
    output logic                 busy,
    output logic                 done,
    output logic [COST_W-1:0]    cost,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [MEM_ABITS-3:0] mem_addr,
    output logic [31:0]          mem_wdata,
    input  logic [31:0]          mem_rdata,
    output logic                 out_valid,
    output logic [31:0]          out_data,
    input  logic                 out_ready
);
    import chain_pkg::*;

    localparam int WW = MEM_ABITS - 2;
    localparam logic [31:0] END_MASK = 32'(1) << END_BIT;

    walk_state_t     state;
    logic [23:0]     cur;
    logic [WW-1:0]   node_w;
    logic [WW-1:0]   clr_w;
    logic [7:0]      count;
    logic [7:0]      idx;
    logic [31:0]     hdr_q;
    logic [31:0]     clr_hdr;
    chain_hdr_t      hdr_in;
    logic            tag, clr_need, clr_last;
    logic [23:0]     rec_ptr;
    logic            start_ok;
    logic            unused_bits;

    assign hdr_in   = mem_rdata;
    assign start_ok = (state == ST_IDLE) && start;
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FIN);
    assign unused_bits = ^{start_addr[31:24], cur[1:0], cur[22:MEM_ABITS],
                           rec_ptr[1:0], rec_ptr[23:MEM_ABITS]};

    chain_cost #(.COST_W(COST_W)) u_cost (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_ok),
        .add   (state == ST_HDR_WAIT),
        .count (hdr_in.count),
        .cost  (cost)
    );

    chain_guard #(.LOOP_LIMIT(LOOP_LIMIT), .CNT_W(CNT_W)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_ok),
        .step     (state == ST_HDR_WAIT),
        .next_ptr (hdr_in.next),
        .clr_load ((state == ST_CHECK) && cur[END_BIT] && clr_need),
        .clr_step (state == ST_CLR_WR),
        .tag      (tag),
        .clr_need (clr_need),
        .clr_last (clr_last),
        .rec_ptr  (rec_ptr)
    );

    // Walk sequencing and stream register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur       <= '0;
            node_w    <= '0;
            clr_w     <= '0;
            count     <= '0;
            idx       <= '0;
            hdr_q     <= '0;
            clr_hdr   <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    cur   <= start_addr[23:0];
                    state <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (!cur[END_BIT])
                        state <= ST_HDR_RD;
                    else if (clr_need) begin
                        clr_w <= rec_ptr[MEM_ABITS-1:2];
                        state <= ST_CLR_RD;
                    end else
                        state <= ST_FIN;
                end
                ST_HDR_RD: begin
                    node_w <= cur[MEM_ABITS-1:2];
                    state  <= ST_HDR_WAIT;
                end
                ST_HDR_WAIT: begin
                    hdr_q <= mem_rdata;
                    count <= hdr_in.count;
                    cur   <= hdr_in.next;
                    idx   <= '0;
                    if (tag)
                        state <= ST_TAG_WR;
                    else if (hdr_in.count != 8'd0)
                        state <= ST_PAY_RD;
                    else
                        state <= ST_CHECK;
                end
                ST_TAG_WR: state <= (count != 8'd0) ? ST_PAY_RD : ST_CHECK;
                ST_PAY_RD: state <= ST_PAY_WAIT;
                ST_PAY_WAIT: begin
                    out_data  <= mem_rdata;
                    out_valid <= 1'b1;
                    state     <= ST_PAY_OUT;
                end
                ST_PAY_OUT: if (out_ready) begin
                    out_valid <= 1'b0;
                    idx       <= idx + 8'd1;
                    state     <= ((idx + 8'd1) == count) ? ST_CHECK : ST_PAY_RD;
                end
                ST_CLR_RD:   state <= ST_CLR_WAIT;
                ST_CLR_WAIT: begin
                    clr_hdr <= mem_rdata;
                    state   <= ST_CLR_WR;
                end
                ST_CLR_WR: begin
                    clr_w <= clr_hdr[MEM_ABITS-1:2];
                    state <= clr_last ? ST_FIN : ST_CLR_RD;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_HDR_RD: begin
                mem_req  = 1'b1;
                mem_addr = cur[MEM_ABITS-1:2];
            end
            ST_TAG_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = node_w;
                mem_wdata = hdr_q | END_MASK;
            end
            ST_PAY_RD: begin
                mem_req  = 1'b1;
                mem_addr = node_w + WW'(idx) + WW'(1);
            end
            ST_CLR_RD: begin
                mem_req  = 1'b1;
                mem_addr = clr_w;
            end
            ST_CLR_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = clr_w;
                mem_wdata = clr_hdr & ~END_MASK;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/chain_walker_chk.sv
// Protocol checker for chain_walker, attached by bind.
// Watches the stream, memory port and busy/done ports only.
module chain_walker_chk #(
    parameter int COST_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [COST_W-1:0] cost,
    input logic              mem_req,
    input logic              out_valid,
    input logic [31:0]       out_data,
    input logic              out_ready
);

    // R6: a stalled word stays put
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R6: no memory traffic while a word waits
    p_stall_nomem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_req);

    // R9: done only while busy
    p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R9: done is a single-cycle pulse, then idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R9: idle block is quiet on both ports
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !out_valid);

    // R9: cost held while idle
    p_cost_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && $past(!busy) |-> $stable(cost));

endmodule

bind chain_walker chain_walker_chk #(.COST_W(COST_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .cost      (cost),
    .mem_req   (mem_req),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
);

// File: tb/chain_walker_test.sv
// Bench for chain_walker: directed corner cases plus seeded random lists,
// checked against a reference walk computed in bench functions.
module chain_walker_test;

    localparam int LIM   = 6;
    localparam int MW    = 1024;
    localparam int COSTW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       start_addr = '0;
    logic              busy, done;
    logic [COSTW-1:0]  cost;
    logic              mem_req, mem_we;
    logic [18:0]       mem_addr;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic              out_valid;
    logic [31:0]       out_data;
    logic              out_ready = 1'b0;

    logic [31:0] mem  [MW];
    logic [31:0] init [MW];
    logic [31:0] refm [MW];
    logic [31:0] got_q[$];
    logic [31:0] exp_q[$];
    longint      exp_cost;
    int          checks = 0;
    int          fails  = 0;
    int          req_cnt = 0;
    int          ready_pct = 100;
    bit          finished = 0;

    always #4 clk = ~clk;

    chain_walker #(.LOOP_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .busy(busy), .done(done), .cost(cost),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    // Memory model, one-cycle read
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:0]];
        end
    end

    // Stream consumer and request counter, away from the active edge
    always @(negedge clk) begin
        out_ready = (($urandom % 100) < ready_pct);
        if (out_valid && out_ready) got_q.push_back(out_data);
        if (mem_req) req_cnt++;
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int widx(logic [23:0] a);
        return int'((a & 24'h1fffff) >> 2) % MW;
    endfunction

    // Reference walk from the requirements
    task automatic ref_walk(logic [31:0] sa);
        logic [23:0] a, rec;
        logic [31:0] h;
        int cnt, w, n;
        bit flag;
        a = sa[23:0]; cnt = 0; flag = 0; rec = '0; exp_cost = 0;
        exp_q.delete();
        while (!a[23]) begin
            w = widx(a); h = refm[w]; n = int'(h[31:24]);
            exp_cost += 10;
            if (n != 0) exp_cost += 5 + n;
            for (int i = 0; i < n; i++) exp_q.push_back(refm[(w + 1 + i) % MW]);
            if (cnt == LIM) begin rec = h[23:0]; flag = 1; end
            else if (cnt > LIM) refm[w] = h | 32'h0080_0000;
            cnt++;
            a = h[23:0];
        end
        if (flag && cnt > LIM + 2) begin
            a = rec;
            for (int k = 0; k < cnt - LIM - 2; k++) begin
                w = widx(a); h = refm[w];
                a = h[23:0] & 24'h1fffff;
                refm[w] = h & ~32'h0080_0000;
            end
        end
    endtask

    // Random list in 16-word slots; cyclic lists close back onto a node
    task automatic build(int n, bit cyclic, int maxlen, output logic [31:0] sa);
        int perm[64];
        int s, t, j;
        logic [23:0] p;
        for (int i = 0; i < MW; i++) mem[i] = $urandom;
        for (int i = 0; i < 64; i++) perm[i] = i;
        for (int i = 63; i > 0; i--) begin
            j = $urandom % (i + 1); t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        end
        for (int k = 0; k < n; k++) begin
            s = perm[k];
            if (k + 1 < n) p = 24'(perm[k+1] * 64) | (24'($urandom % 4) << 21);
            else if (cyclic) p = 24'(perm[$urandom % n] * 64);
            else p = 24'h80_0000 | 24'($urandom % 24'h80_0000);
            mem[s*16] = {8'($urandom % (maxlen + 1)), p};
        end
        sa = {8'($urandom), 1'b0, 2'($urandom), 21'(perm[0] * 64)};
    endtask

    // One walk with full checking; inj issues a start mid-walk (R10)
    task automatic run(logic [31:0] sa, bit inj, string tag);
        bit same;
        int guard;
        for (int i = 0; i < MW; i++) begin init[i] = mem[i]; refm[i] = mem[i]; end
        ref_walk(sa);
        got_q.delete(); req_cnt = 0;
        @(negedge clk); start = 1'b1; start_addr = sa;
        @(negedge clk); start = 1'b0; start_addr = $urandom;
        guard = 0;
        while (!done) begin
            if (inj && guard == 3 && busy) begin start = 1'b1; start_addr = 32'h0000_0040; end
            else start = 1'b0;
            @(negedge clk); guard++;
        end
        start = 1'b0;
        check(busy == 1'b1, {"R9 busy at done ", tag}, busy, 1);
        check(cost == COSTW'(exp_cost), {"R5 cost ", tag}, cost, exp_cost);
        check(got_q.size() == exp_q.size(), {"R2 R4 word count ", tag}, got_q.size(), exp_q.size());
        same = (got_q.size() == exp_q.size());
        for (int i = 0; same && i < exp_q.size(); i++) same = (got_q[i] === exp_q[i]);
        check(same, {"R2 R3 R7 stream words ", tag}, got_q.size(), exp_q.size());
        @(negedge clk);
        check(busy == 1'b0, {"R9 idle after done ", tag}, busy, 0);
        same = 1;
        for (int i = 0; i < MW; i++) if (mem[i] !== init[i] || refm[i] !== init[i]) same = 0;
        check(same, {"R8 memory restored ", tag}, same, 1);
        repeat (2) @(negedge clk);
        check(cost == COSTW'(exp_cost), {"R9 cost held ", tag}, cost, exp_cost);
    endtask

    initial begin
        logic [31:0] sa;
        void'($urandom(32'd1234));
        for (int i = 0; i < MW; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && out_valid == 0 && mem_req == 0,
              "R9 reset state", {busy, done, out_valid, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: start already at the end marker, junk in bits 31:24
        run(32'h5A80_1234, 0, "end-at-start");
        check(req_cnt == 0, "R1 no memory access", req_cnt, 0);
        check(cost == 0, "R1 zero cost", cost, 0);

        // R4: three zero-count packets
        for (int i = 0; i < MW; i++) mem[i] = $urandom;
        mem[0]   = {8'd0, 24'h000040};
        mem[16]  = {8'd0, 24'h600080};
        mem[32]  = {8'd0, 24'h800000};
        run(32'hFF00_0000, 0, "zero-count");
        check(got_q.size() == 0 && cost == 30, "R4 R5 zero-count chain", cost, 30);

        // R5: one packet of one word
        mem[0] = {8'd1, 24'h800000};
        mem[1] = 32'hCAFE_F00D;
        run(32'h0000_0000, 0, "single");
        check(cost == 16, "R5 single packet cost", cost, 16);

        // R8: long straight chain past the threshold, full ready
        build(12, 0, 3, sa);
        run(sa, 0, "long-straight");

        // R7: cyclic chains
        ready_pct = 60;
        for (int k = 0; k < 8; k++) begin
            build(2 + ($urandom % 10), 1, 6, sa);
            run(sa, 0, "cyclic");
        end

        // Random straight chains with back-pressure (R6)
        ready_pct = 40;
        for (int k = 0; k < 12; k++) begin
            build(1 + ($urandom % 12), 0, 15, sa);
            run(sa, 0, "random");
        end

        // R10: start pulse while busy
        ready_pct = 70;
        build(5, 0, 4, sa);
        run(sa, 1, "restart-ignored R10");

        summary();
    end

endmodule